// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block issues the column address for every beat of a memory burst. A controller pulses `start_i` together with a starting column, a burst-length code and an ordering select. In that same cycle the block shows the starting column on `col_o`. It then presents one further column per clock until the programmed number of beats has been issued. `valid_o` marks each beat and `last_o` marks the final one.

Only the low column bits that fall inside the burst window take part in the ordering. The window is one bit for length 2, two bits for length 4 and three bits for length 8. Two orderings are offered:

- **Sequential:** counts up from the start offset and wraps inside the window.
- **Interleaved:** combines the start offset and the beat index by exclusive-or.

Every column bit outside the window is carried through from the start column unchanged.

A new start pulse always wins. If it arrives while a burst is running, the old burst is dropped and the new burst's first column appears at once.

Top module: `burst_col_seq`

## Requirements
- R1: `len_sel_i` is decoded as 00 = 1 beat, 01 = 2 beats, 10 = 4 beats, 11 = 8 beats; `valid_o` is high for exactly that many consecutive cycles, counting from the cycle of `start_i`.
- R2: In the cycle `start_i` is high, `valid_o` is high and `col_o` equals `start_col_i`.
- R3: With `ilv_i` = 0 (sequential), beat k carries window offset (s + k) mod L, where s is the start offset inside the window and L is the burst length (for example, start 1 with length 4 gives 1, 2, 3, 0).
- R4: With `ilv_i` = 1 (interleaved), beat k carries window offset s XOR k (for example, start 5 with length 8 gives 5, 4, 7, 6, 1, 0, 3, 2).
- R5: The window occupies column bits [0], [1:0] or [2:0] for lengths 2, 4 and 8. Every column bit outside the window equals the start column on every beat of the burst.
- R6: `last_o` is high only on the final beat. In the following cycle `valid_o` is low, unless `start_i` is high in that cycle.
- R7: A `start_i` pulse during a running burst abandons that burst. The new first column appears in the same cycle, and the new burst runs for its full length.
- R8: When the start offset inside the window is zero, the sequential and interleaved orderings give the same ascending sequence.
- R9: A 1-beat burst presents only the start column, with `valid_o` and `last_o` both high, and nothing follows it.
- R10: While `rst_n` is low, and until a start after its release, `valid_o` and `last_o` are low. A reset taken mid-burst ends that burst.
- R11: `start_col_i`, `len_sel_i` and `ilv_i` are sampled only in the cycle `start_i` is high. Changing them during a burst does not alter the remaining beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst this cycle |
| start_col_i | input | COL_W | Starting column address |
| len_sel_i | input | 2 | Burst length code (00=1, 01=2, 10=4, 11=8) |
| ilv_i | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The presented beat is the final one |

## Verification
Two functions can fall in the same cycle: the final beat of a running burst and the first beat of a new burst. A restart can also land in the middle of a burst. The bench provokes the first case by raising `start_i` in the cycle right after a 2-beat burst's last beat. It judges that `valid_o` never drops and that the new start column appears at once. It provokes the second case by restarting an 8-beat burst after its third beat. There it judges that the new burst's first column replaces the old fourth beat and that the new burst then runs for its own full length.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Width of the ordering window for the longest supported burst (8 beats).
  localparam int unsigned WIN_W = 3;

  typedef logic [WIN_W-1:0] win_t;

  typedef enum logic [1:0] {
    BLEN_1 = 2'b00,
    BLEN_2 = 2'b01,
    BLEN_4 = 2'b10,
    BLEN_8 = 2'b11
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } ord_e;

endpackage

// File: rtl/bcg_rst_sync.sv
module bcg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // Asserts asynchronously, releases after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import burst_col_pkg::*;
(
  input  blen_e len_i,
  output win_t  mask_o,
  output win_t  last_idx_o
);

  // Window bit i belongs to the burst when the length code exceeds i.
  for (genvar i = 0; i < WIN_W; i++) begin : g_mask
    assign mask_o[i] = (int'(len_i) > i);
  end

  // Final beat index equals length minus one, which is the window mask.
  assign last_idx_o = mask_o;

endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
  import burst_col_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  win_t new_last_i,
  output logic busy_o,
  output win_t beat_o,
  output logic final_o
);

  logic busy_q, busy_d;
  win_t beat_q, beat_d;
  win_t last_q, last_d;
  logic upd_en;

  assign upd_en = start_i | busy_q;

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    last_d = last_q;
    if (start_i) begin
      // Beat 0 is shown combinationally; the register continues from beat 1.
      busy_d = (new_last_i != '0);
      beat_d = win_t'(1);
      last_d = new_last_i;
    end else if (busy_q) begin
      if (beat_q == last_q) begin
        busy_d = 1'b0;
        beat_d = '0;
      end else begin
        beat_d = beat_q + win_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      last_q <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      last_q <= last_d;
    end
  end

  assign busy_o  = busy_q;
  assign beat_o  = beat_q;
  assign final_o = busy_q && (beat_q == last_q);

  p_beat_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (beat_q <= last_q))
    else $error("beat index beyond burst length");

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && new_last_i != '0) |=> (busy_q && beat_q == win_t'(1)))
    else $error("restart did not resume at beat 1");

  p_idle_after_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (final_o && !start_i) |=> !busy_q)
    else $error("burst continued past its final beat");

  p_single_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && new_last_i == '0) |=> !busy_q)
    else $error("one-beat burst left the sequencer busy");

endmodule

// File: rtl/bcg_offset_calc.sv
module bcg_offset_calc
  import burst_col_pkg::*;
(
  input  win_t base_i,
  input  win_t beat_i,
  input  win_t mask_i,
  input  logic ilv_i,
  output win_t off_o
);

  win_t seq_off;
  win_t ilv_off;
  win_t pick;

  // Sequential: add and let the mask wrap the carry out of the window.
  assign seq_off = base_i + beat_i;
  // Interleaved: beat index toggles bits of the start offset.
  assign ilv_off = base_i ^ beat_i;

  assign pick = (ord_e'(ilv_i) == ORD_ILV) ? ilv_off : seq_off;

  // Bits inside the window follow the order; bits outside keep the start value.
  for (genvar i = 0; i < WIN_W; i++) begin : g_merge
    assign off_o[i] = mask_i[i] ? pick[i] : base_i[i];
  end

  always_comb begin
    p_zero_start_match_r8: assert (((base_i & mask_i) != '0) ||
                                   ((seq_off & mask_i) == (ilv_off & mask_i)))
      else $error("orderings differ for zero start offset");
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       len_sel_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  localparam int unsigned UP_W = COL_W - WIN_W;

  logic             rst_sync_n;
  win_t             new_mask;
  win_t             new_last;
  logic             busy;
  win_t             beat;
  logic             final_beat;
  win_t             off;

  logic [COL_W-1:0] col_q, col_d;
  win_t             mask_q, mask_d;
  logic             ilv_q, ilv_d;

  bcg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcg_len_decode u_len_decode (
    .len_i      (blen_e'(len_sel_i)),
    .mask_o     (new_mask),
    .last_idx_o (new_last)
  );

  bcg_beat_ctrl u_beat_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .new_last_i (new_last),
    .busy_o     (busy),
    .beat_o     (beat),
    .final_o    (final_beat)
  );

  // Burst context captured only on a start pulse.
  always_comb begin
    col_d  = start_col_i;
    mask_d = new_mask;
    ilv_d  = ilv_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      col_q  <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      col_q  <= col_d;
      mask_q <= mask_d;
      ilv_q  <= ilv_d;
    end
  end

  bcg_offset_calc u_offset_calc (
    .base_i (col_q[WIN_W-1:0]),
    .beat_i (beat),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .off_o  (off)
  );

  // Beat 0 bypasses the registers so it lands in the start cycle.
  always_comb begin
    if (start_i && rst_sync_n) begin
      col_o   = start_col_i;
      valid_o = 1'b1;
      last_o  = (new_last == '0);
    end else begin
      col_o   = {col_q[COL_W-1:WIN_W], off};
      valid_o = busy;
      last_o  = final_beat;
    end
  end

  p_upper_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_o && !start_i) |-> (col_o[COL_W-1:WIN_W] == $past(col_o[COL_W-1:WIN_W])))
    else $error("column bits above the window moved during a burst");

  p_last_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    last_o |=> (!valid_o || start_i))
    else $error("valid stayed high after the last beat");

  p_last_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    last_o |-> valid_o)
    else $error("last flag without a valid beat");

  p_reset_quiet_r10: assert property (@(posedge clk)
    (!rst_sync_n && !start_i) |-> (!valid_o && !last_o))
    else $error("outputs active during reset");

  initial begin
    p_width_ok: assert (UP_W >= 1) else $error("COL_W must exceed the window width");
  end

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

  localparam int unsigned COL_W = 10;

  typedef struct packed {
    logic [9:0]  col;
    logic [1:0]  len;
    logic        il;
    logic [3:0]  n;
    logic [23:0] seq;   // beat k low bits at [3k+:3]
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{10'h2A3, 2'b11, 1'b0, 4'd8, {3'd2,3'd1,3'd0,3'd7,3'd6,3'd5,3'd4,3'd3}},
    '{10'h155, 2'b11, 1'b1, 4'd8, {3'd2,3'd3,3'd0,3'd1,3'd6,3'd7,3'd4,3'd5}},
    '{10'h3FD, 2'b10, 1'b0, 4'd4, {12'd0,3'd4,3'd7,3'd6,3'd5}},
    '{10'h00B, 2'b10, 1'b1, 4'd4, {12'd0,3'd0,3'd1,3'd2,3'd3}},
    '{10'h1C7, 2'b01, 1'b0, 4'd2, {18'd0,3'd6,3'd7}},
    '{10'h268, 2'b01, 1'b1, 4'd2, {18'd0,3'd1,3'd0}},
    '{10'h080, 2'b11, 1'b1, 4'd8, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}},
    '{10'h3F8, 2'b11, 1'b0, 4'd8, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}},
    '{10'h0F2, 2'b10, 1'b1, 4'd4, {12'd0,3'd1,3'd0,3'd3,3'd2}},
    '{10'h11E, 2'b00, 1'b0, 4'd1, {21'd0,3'd6}}
  };

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [1:0]       len_sel_i;
  logic             ilv_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int n_checks = 0;
  int n_fail   = 0;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_sel_i   (len_sel_i),
    .ilv_i       (ilv_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic check_beat(input string tag, input logic [COL_W-1:0] exp_col,
                            input logic exp_last);
    n_checks++;
    if (!(valid_o === 1'b1 && col_o === exp_col && last_o === exp_last)) begin
      n_fail++;
      $display("FAIL %s: valid=%b col=%h last=%b expected valid=1 col=%h last=%b",
               tag, valid_o, col_o, last_o, exp_col, exp_last);
    end
  endtask

  task automatic check_idle(input string tag);
    n_checks++;
    if (!(valid_o === 1'b0 && last_o === 1'b0)) begin
      n_fail++;
      $display("FAIL %s: valid=%b last=%b expected valid=0 last=0", tag, valid_o, last_o);
    end
  endtask

  // Start a burst at the next falling edge (beat 0 is then visible).
  task automatic kick(input logic [9:0] col, input logic [1:0] len, input logic il);
    @(negedge clk);
    start_i     = 1'b1;
    start_col_i = col;
    len_sel_i   = len;
    ilv_i       = il;
    #1;
  endtask

  // Advance one cycle with start low and scrambled inputs (R11).
  task automatic step(input logic [9:0] col, input logic [1:0] len, input logic il);
    @(negedge clk);
    start_i     = 1'b0;
    start_col_i = ~col;
    len_sel_i   = ~len;
    ilv_i       = ~il;
    #1;
  endtask

  initial begin
    rst_n       = 1'b0;
    start_i     = 1'b0;
    start_col_i = '0;
    len_sel_i   = 2'b00;
    ilv_i       = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check_idle("R10 outputs during reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check_idle("R10 outputs after reset release");

    // Table walk: R1 R2 R3 R4 R5 R6 R8 R9 R11
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(TBL[v].n); k++) begin
        if (k == 0) kick(TBL[v].col, TBL[v].len, TBL[v].il);
        else        step(TBL[v].col, TBL[v].len, TBL[v].il);
        check_beat($sformatf("R1/R3/R4/R5 vector %0d beat %0d", v, k),
                   {TBL[v].col[9:3], TBL[v].seq[3*k +: 3]},
                   (k == int'(TBL[v].n) - 1));
      end
      step(TBL[v].col, TBL[v].len, TBL[v].il);
      check_idle($sformatf("R6 idle after vector %0d", v));
    end

    // R7: restart an 8-beat sequential burst after three beats.
    kick(10'h200, 2'b11, 1'b0);
    check_beat("R7 first burst beat 0", 10'h200, 1'b0);
    step(10'h200, 2'b11, 1'b0);
    check_beat("R7 first burst beat 1", 10'h201, 1'b0);
    step(10'h200, 2'b11, 1'b0);
    check_beat("R7 first burst beat 2", 10'h202, 1'b0);
    kick(10'h0F2, 2'b10, 1'b1);
    check_beat("R7 restart beat 0", 10'h0F2, 1'b0);
    step(10'h0F2, 2'b10, 1'b1);
    check_beat("R7 restart beat 1", 10'h0F3, 1'b0);
    step(10'h0F2, 2'b10, 1'b1);
    check_beat("R7 restart beat 2", 10'h0F0, 1'b0);
    step(10'h0F2, 2'b10, 1'b1);
    check_beat("R7 restart beat 3", 10'h0F1, 1'b1);
    step(10'h0F2, 2'b10, 1'b1);
    check_idle("R7 idle after restarted burst");

    // R6: back-to-back start right after a last beat keeps valid high.
    kick(10'h001, 2'b01, 1'b0);
    check_beat("R6 b2b first beat 0", 10'h001, 1'b0);
    step(10'h001, 2'b01, 1'b0);
    check_beat("R6 b2b first beat 1", 10'h000, 1'b1);
    kick(10'h3FF, 2'b01, 1'b1);
    check_beat("R6 b2b second beat 0", 10'h3FF, 1'b0);
    step(10'h3FF, 2'b01, 1'b1);
    check_beat("R6 b2b second beat 1", 10'h3FE, 1'b1);
    step(10'h3FF, 2'b01, 1'b1);
    check_idle("R6 idle after back-to-back");

    // R9: two single-beat bursts in consecutive cycles.
    kick(10'h045, 2'b00, 1'b1);
    check_beat("R9 single beat A", 10'h045, 1'b1);
    kick(10'h2B9, 2'b00, 1'b0);
    check_beat("R9 single beat B", 10'h2B9, 1'b1);
    step(10'h2B9, 2'b00, 1'b0);
    check_idle("R9 nothing after single beat");

    // R10: reset taken mid-burst ends it.
    kick(10'h300, 2'b11, 1'b0);
    step(10'h300, 2'b11, 1'b0);
    check_beat("R10 pre-reset beat 1", 10'h301, 1'b0);
    rst_n = 1'b0;
    #1;
    check_idle("R10 mid-burst reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check_idle("R10 no resume after reset");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish (R1) actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule